// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Master

This block is a synchronous serial master for half-duplex command/response links. Software or a neighbouring block writes 8-bit command bytes into a small transmit queue. Whenever the queue holds a byte and the link is idle, the master asserts an active-low frame select and shifts the command out MSB first. It then leaves one idle serial clock for the slave to decode the command. After that it samples a response of programmable width, from 4 to 16 bits, and stores it in a receive queue.

The serial clock idles low and runs only while a frame is open. The slave captures data on rising edges and changes its data on falling edges. In single-frame mode, frame select returns high after every response. In chained mode, frame select stays low, and the next queued command follows the last response bit directly for as long as commands are waiting.

Top module: `mw_master`

## Requirements
- R1: After reset, frame select `fss_no` is high, `sclk_o` and `mosi_o` are low, both queues report empty, and `rx_ovr_o` is low.
- R2: While a frame is open, `sclk_o` has a period of 2*(`div_i`+1) system clocks and starts each period low. Whenever `fss_no` is high, `sclk_o` is low.
- R3: When the transmit queue is not empty and the link is idle, the oldest byte is popped and `fss_no` goes low. Bit 7 of that byte is on `mosi_o` in the same cycle. The remaining bits follow MSB first, and `mosi_o` changes only on falling edges of `sclk_o`.
- R4: After the eighth command bit there is one serial clock with no sampling. Then N response bits are sampled on rising edges, MSB first. N is `resp_bits_i` clamped to the range 4..16 and is captured when the frame starts.
- R5: The response is pushed into the receive queue right-justified in a 16-bit entry, with the unused upper bits zero.
- R6: With `cont_i` low, a frame has exactly 9+N rising `sclk_o` edges while `fss_no` is low. `fss_no` rises one full serial period after the rising edge that sampled the last response bit.
- R7: With `cont_i` high and a byte waiting when a response completes, the next command starts at the following falling edge and `fss_no` stays low. A chain of k frames shows k*(9+N) rising edges and a single rise of `fss_no`.
- R8: Each queue holds 8 entries, preserves first-in first-out order and reports full and empty. A write to a full transmit queue is dropped.
- R9: If the receive queue is full when a response completes, the response is dropped and `rx_ovr_o` is set. It stays set until reset.
- R10: `rx_rd_i` removes the head of the receive queue, which is visible on `rx_data_o` beforehand. A read of an empty receive queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Push a command byte |
| tx_data_i | input | 8 | Command byte |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_rd_i | input | 1 | Pop a response word |
| rx_data_o | output | 16 | Head of receive queue |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_ovr_o | output | 1 | Sticky receive overrun |
| cont_i | input | 1 | Chain frames while commands wait |
| resp_bits_i | input | 5 | Response width, clamped to 4..16 |
| div_i | input | 8 | Serial half-period minus one, in system clocks |
| sclk_o | output | 1 | Serial clock |
| fss_no | output | 1 | Frame select, active low |
| mosi_o | output | 1 | Command data out |
| miso_i | input | 1 | Response data in |

## Verification
A byte written to an idle master is popped two system clocks later, and frame select falls in that same edge. Every later serial event lands a whole number of half-periods of (`div_i`+1) system clocks after that edge. The response enters the receive queue at the rising edge that samples its last bit, and frame select rises two half-periods after that edge. The bench therefore times these events by `$time` at the observed serial-clock and frame-select edges rather than by fixed delays. A slave model reacts to serial-clock edges exactly as the slave timing rules demand. Queue contents and flags are read at falling system-clock edges once a frame or chain has closed.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned RESP_MAX = 16;
  localparam int unsigned RESP_MIN = 4;
  localparam int unsigned LEN_W    = $clog2(RESP_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WAIT, ST_RESP, ST_LAST, ST_TAIL
  } mw_state_e;

  function automatic logic [LEN_W-1:0] mw_clamp_len(input logic [LEN_W-1:0] b);
    if (b < LEN_W'(RESP_MIN)) return LEN_W'(RESP_MIN);
    if (b > LEN_W'(RESP_MAX)) return LEN_W'(RESP_MAX);
    return b;
  endfunction
endpackage

// File: rtl/mw_fifo.sv
module mw_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_wr, do_rd;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_wr   = wr_i & ~full_o;
  assign do_rd   = rd_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= bump(wptr_q);
      if (do_rd) rptr_q <= bump(rptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8: a write into a full queue leaves it unchanged
  p_drop_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !rd_i |=> full_o && $stable(wptr_q));
  // R10: reading an empty queue does nothing
  p_rd_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i && !wr_i |=> empty_o && $stable(rptr_q));
endmodule

// File: rtl/mw_tick_div.sv
module mw_tick_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i & (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R2: no tick while disabled
  p_no_tick_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/mw_frame_eng.sv
module mw_frame_eng
  import mw_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  output logic                busy_o,
  input  logic                cont_i,
  input  logic [LEN_W-1:0]    resp_bits_i,
  input  logic                tx_empty_i,
  input  logic [CMD_W-1:0]    tx_data_i,
  output logic                tx_pop_o,
  input  logic                miso_i,
  output logic                rx_push_o,
  output logic [RESP_MAX-1:0] rx_word_o,
  output logic                sclk_o,
  output logic                fss_no,
  output logic                mosi_o
);
  mw_state_e            state_q;
  logic [CMD_W-2:0]     tx_sh_q;
  logic [RESP_MAX-2:0]  rx_sh_q;
  logic [LEN_W-1:0]     bcnt_q, nlen_q;
  logic                 sclk_q, fss_q, mosi_q;
  logic                 rise, fall, start, chain, last_bit;

  assign rise      = tick_i & ~sclk_q;
  assign fall      = tick_i &  sclk_q;
  assign start     = (state_q == ST_IDLE) & ~tx_empty_i;
  assign chain     = (state_q == ST_LAST) & fall & cont_i & ~tx_empty_i;
  assign tx_pop_o  = start | chain;
  assign last_bit  = (bcnt_q == nlen_q - 1'b1);
  assign rx_word_o = {rx_sh_q, miso_i};
  assign rx_push_o = (state_q == ST_RESP) & rise & last_bit;
  assign busy_o    = (state_q != ST_IDLE);
  assign sclk_o    = sclk_q;
  assign fss_no    = fss_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bcnt_q  <= '0;
      nlen_q  <= LEN_W'(RESP_MIN);
      sclk_q  <= 1'b0;
      fss_q   <= 1'b1;
      mosi_q  <= 1'b0;
    end else begin
      if (state_q == ST_IDLE)                      sclk_q <= 1'b0;
      else if (tick_i && !(state_q == ST_TAIL && rise)) sclk_q <= ~sclk_q;

      if (start || chain) begin
        state_q <= ST_CMD;
        fss_q   <= 1'b0;
        tx_sh_q <= tx_data_i[CMD_W-2:0];
        mosi_q  <= tx_data_i[CMD_W-1];
        rx_sh_q <= '0;
        bcnt_q  <= '0;
        nlen_q  <= mw_clamp_len(resp_bits_i);
      end else begin
        unique case (state_q)
          ST_CMD: if (fall) begin
            if (bcnt_q == LEN_W'(CMD_W - 1)) begin
              state_q <= ST_WAIT;
              mosi_q  <= 1'b0;
            end else begin
              mosi_q  <= tx_sh_q[CMD_W-2];
              tx_sh_q <= {tx_sh_q[CMD_W-3:0], 1'b0};
              bcnt_q  <= bcnt_q + 1'b1;
            end
          end
          ST_WAIT: if (fall) begin
            state_q <= ST_RESP;
            bcnt_q  <= '0;
          end
          ST_RESP: if (rise) begin
            rx_sh_q <= rx_word_o[RESP_MAX-2:0];
            bcnt_q  <= bcnt_q + 1'b1;
            if (last_bit) state_q <= ST_LAST;
          end
          ST_LAST: if (fall) state_q <= ST_TAIL;
          ST_TAIL: if (rise) begin
            state_q <= ST_IDLE;
            fss_q   <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: serial clock parked low whenever frame select is high
  p_sclk_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fss_q |-> !sclk_q);
  // R2: serial clock only moves on a divider tick
  p_sclk_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sclk_q));
  // R3: a pop opens the frame with the command MSB on the line
  p_cmd_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !fss_q && (mosi_q == $past(tx_data_i[CMD_W-1])));
  // R3: data line only changes at a falling edge or a frame open
  p_mosi_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall && !start |=> $stable(mosi_q));
  // R6: frame closes at the rising tick of the tail period
  p_tail_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL) && rise |=> fss_q && !sclk_q);
  // R7: chaining keeps frame select low
  p_chain_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain |=> !fss_q);
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_wr_i,
  input  logic [CMD_W-1:0]    tx_data_i,
  output logic                tx_full_o,
  output logic                tx_empty_o,
  input  logic                rx_rd_i,
  output logic [RESP_MAX-1:0] rx_data_o,
  output logic                rx_full_o,
  output logic                rx_empty_o,
  output logic                rx_ovr_o,
  input  logic                cont_i,
  input  logic [LEN_W-1:0]    resp_bits_i,
  input  logic [DIV_W-1:0]    div_i,
  output logic                sclk_o,
  output logic                fss_no,
  output logic                mosi_o,
  input  logic                miso_i
);
  logic                tx_pop, rx_push, busy, tick, ovr_q;
  logic [CMD_W-1:0]    tx_head;
  logic [RESP_MAX-1:0] rx_word;

  mw_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .wr_i(tx_wr_i), .wdata_i(tx_data_i),
    .rd_i(tx_pop),  .rdata_o(tx_head),
    .full_o(tx_full_o), .empty_o(tx_empty_o)
  );

  mw_fifo #(.WIDTH(RESP_MAX), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .wr_i(rx_push), .wdata_i(rx_word),
    .rd_i(rx_rd_i), .rdata_o(rx_data_o),
    .full_o(rx_full_o), .empty_o(rx_empty_o)
  );

  mw_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .en_i(busy), .div_i, .tick_o(tick)
  );

  mw_frame_eng u_eng (
    .clk_i, .rst_ni,
    .tick_i(tick), .busy_o(busy),
    .cont_i, .resp_bits_i,
    .tx_empty_i(tx_empty_o), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .miso_i, .rx_push_o(rx_push), .rx_word_o(rx_word),
    .sclk_o, .fss_no, .mosi_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ovr_q <= 1'b0;
    else if (rx_push && rx_full_o)  ovr_q <= 1'b1;
  end
  assign rx_ovr_o = ovr_q;

  // R9: response into a full queue raises overrun
  p_ovr_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push && rx_full_o && !rx_rd_i |=> rx_ovr_o && rx_full_o);
  // R9: overrun is sticky
  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_o |=> rx_ovr_o);
  // R3: a pop only happens with a byte present
  p_pop_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> !tx_empty_o);
endmodule

// File: tb/mw_master_tb_top.sv
module mw_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, cont = 1'b0, miso = 1'b0;
  logic [7:0]  tx_data = '0, div = '0;
  logic [4:0]  resp_bits = 5'd8;
  logic [15:0] rx_data;
  logic        tx_full, tx_empty, rx_full, rx_empty, rx_ovr, sclk, fss_n, mosi;

  int n_checks = 0, n_fail = 0;
  int cur_n = 8;
  int s_cnt = 0, fr_rises = 0, fss_rises = 0;
  time last_rise_t = 0;
  logic [7:0] s_ctrl = '0;
  logic [7:0] got_ctrl[$];

  always #5 clk = ~clk;

  mw_master dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .rx_ovr_o(rx_ovr), .cont_i(cont), .resp_bits_i(resp_bits), .div_i(div),
    .sclk_o(sclk), .fss_no(fss_n), .mosi_o(mosi), .miso_i(miso)
  );

  function automatic int eff_len(input int b);
    return (b < 4) ? 4 : (b > 16) ? 16 : b;
  endfunction

  function automatic logic [15:0] resp_of(input logic [7:0] c, input int n);
    logic [31:0] m;
    m = (32'h1 << n) - 1;
    return {c, c ^ 8'h5A} & m[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: latch on rise, drive on fall
  always @(posedge sclk) begin
    last_rise_t = $time;
    if (!fss_n) begin
      fr_rises++;
      if (s_cnt < 8) s_ctrl = {s_ctrl[6:0], mosi};
      s_cnt++;
      if (s_cnt == 9 + cur_n) begin
        got_ctrl.push_back(s_ctrl);
        s_cnt = 0;
      end
    end
  end
  always @(negedge sclk) begin
    if (!fss_n && s_cnt >= 9 && s_cnt < 9 + cur_n) begin
      logic [15:0] r;
      r = resp_of(s_ctrl, cur_n);
      miso = r[cur_n - 1 - (s_cnt - 9)];
    end else miso = 1'b0;
  end
  always @(posedge fss_n) begin
    fss_rises++;
    s_cnt = 0;
  end

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_check(input logic [15:0] exp, input string req);
    @(negedge clk);
    check(!rx_empty, "R10 rx not empty", {31'b0, rx_empty}, 0);
    check(rx_data == exp, req, rx_data, exp);
    rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic run_single(input logic [7:0] c, input int b, input int d);
    time t0, t1;
    int n;
    n = eff_len(b);
    cont = 1'b0; resp_bits = 5'(b); div = 8'(d); cur_n = n;
    fr_rises = 0; fss_rises = 0; got_ctrl.delete();
    push_byte(c);
    if (fss_n) @(negedge fss_n);
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    check((t1 - t0) == 2 * (d + 1) * 10, "R2 sclk period", 32'(t1 - t0), 32'(2 * (d + 1) * 10));
    @(posedge fss_n);
    check((($time - last_rise_t) == 2 * (d + 1) * 10), "R6 fss rise delay",
          32'($time - last_rise_t), 32'(2 * (d + 1) * 10));
    check(fr_rises == 9 + n, "R6 rises per frame", 32'(fr_rises), 32'(9 + n));
    check(got_ctrl.size() == 1 && got_ctrl[0] == c, "R3 command bits",
          (got_ctrl.size() > 0) ? 32'(got_ctrl[0]) : 32'hFFFF, 32'(c));
    @(negedge clk);
    check(!sclk, "R2 sclk idle low", {31'b0, sclk}, 0);
    pop_check(resp_of(c, n), "R4 R5 response word");
    check(rx_empty, "R10 rx empty after pop", {31'b0, rx_empty}, 1);
  endtask

  task automatic run_chain(input int k, input int b, input int d);
    logic [7:0] bytes[$];
    int n;
    n = eff_len(b);
    cont = 1'b1; resp_bits = 5'(b); div = 8'(d); cur_n = n;
    fr_rises = 0; fss_rises = 0; got_ctrl.delete();
    for (int i = 0; i < k; i++) bytes.push_back(8'($urandom));
    @(negedge clk);
    for (int i = 0; i < k; i++) begin
      tx_wr = 1'b1; tx_data = bytes[i];
      @(negedge clk);
    end
    tx_wr = 1'b0;
    @(posedge fss_n);
    @(negedge clk);
    check(fss_rises == 1, "R7 fss stays low across chain", 32'(fss_rises), 1);
    check(fr_rises == k * (9 + n), "R7 chain rises", 32'(fr_rises), 32'(k * (9 + n)));
    for (int i = 0; i < k; i++) begin
      check(i < got_ctrl.size() && got_ctrl[i] == bytes[i], "R7 chained command order",
            (i < got_ctrl.size()) ? 32'(got_ctrl[i]) : 32'hFFFF, 32'(bytes[i]));
      pop_check(resp_of(bytes[i], n), "R8 chained response order");
    end
    cont = 1'b0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=150000", wd);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] burst[10];
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fss_n && !sclk && !mosi, "R1 serial lines idle", {29'b0, fss_n, sclk, mosi}, 3'b100);
    check(tx_empty && rx_empty && !tx_full && !rx_full, "R1 queues empty",
          {28'b0, tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    check(!rx_ovr, "R1 overrun clear", {31'b0, rx_ovr}, 0);
    // R10 read on empty queue is ignored
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
    check(rx_empty && !rx_full, "R10 read of empty ignored", {30'b0, rx_empty, rx_full}, 2'b10);

    // directed corner cases
    run_single(8'hA5, 16, 0);
    run_single(8'h3C, 4, 1);
    run_single(8'hC3, 2, 0);   // R4 clamp up to 4
    run_single(8'h96, 20, 2);  // R4 clamp down to 16
    run_single(8'h01, 13, 3);

    // random single frames
    for (int i = 0; i < 10; i++)
      run_single(8'($urandom), 4 + int'($urandom % 13), int'($urandom % 4));

    // R7 chained frames
    run_chain(3, 4 + int'($urandom % 13), int'($urandom % 3));
    run_chain(4, 9, 0);
    // chain mode with a single byte behaves like one frame
    run_chain(1, 6, 1);

    // R8 R9: overfill both queues
    cont = 1'b0; resp_bits = 5'd4; div = 8'd3; cur_n = 4;
    got_ctrl.delete();
    for (int i = 0; i < 10; i++) burst[i] = 8'($urandom);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      tx_wr = 1'b1; tx_data = burst[i];
      @(negedge clk);
    end
    tx_wr = 1'b0;
    check(tx_full, "R8 tx full after burst", {31'b0, tx_full}, 1);
    while (got_ctrl.size() < 9 || !fss_n || !tx_empty) @(negedge clk);
    repeat (4) @(negedge clk);
    check(got_ctrl.size() == 9, "R8 write into full tx dropped", 32'(got_ctrl.size()), 9);
    check(rx_full, "R8 rx full", {31'b0, rx_full}, 1);
    check(rx_ovr, "R9 overrun set", {31'b0, rx_ovr}, 1);
    for (int i = 0; i < 8; i++) pop_check(resp_of(burst[i], 4), "R9 first eight kept");
    check(rx_empty, "R9 ninth response dropped", {31'b0, rx_empty}, 1);
    check(rx_ovr, "R9 overrun sticky", {31'b0, rx_ovr}, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule